// File: doc/BRIEF.md
# Per-Field Masked Calendar Alarm

This block compares a live calendar, kept outside it in BCD, against six alarm bytes: seconds, minutes, hours, weekday, day of month and month. Each alarm byte carries its own compare-enable bit next to the BCD value. Any subset of fields can therefore make up the wake-up condition, for example "every day at 07:30:00" or "every Monday".

The match is taken only in the cycle in which the calendar announces a new second, through a one-cycle `tick_sec` pulse. A matching second therefore raises the alarm once and not on every clock cycle of that second. A match sets a sticky flag. The interrupt output is that flag gated by an interrupt enable.

The host programs the alarm bytes and the control byte through one byte-wide register port. Writes take effect at the clock edge and reads are combinational.

Top module: `alarm_match`

## Requirements
- R1: Alarm bytes sit at register addresses 0 to 5, in the order seconds, minutes, hours, weekday, day of month, month. Each byte reads back exactly as written and reads 0 after reset.
- R2: Bit 7 of an alarm byte enables that field, and bits 6:0 hold its BCD value. An enabled field matches when bits 6:0 equal bits 6:0 of the calendar field, and the calendar's bit 7 plays no part. Calendar field i occupies `cal_time[8*i+7:8*i]` in the same order as R1, and the month runs 1 to 12 in both places.
- R3: A field whose enable bit is 0 does not affect the match, whatever its value.
- R4: When no field is enabled, no alarm is ever raised.
- R5: The match is evaluated only in a cycle with `tick_sec` high, and the flag sets at that clock edge. A matching calendar with no tick sets nothing.
- R6: The control byte is at address 6. Bit 0 is the alarm flag and bit 3 is the interrupt enable, and all other bits read 0. Writing 0 to bit 0 clears the flag, while writing 1 to bit 0 leaves it unchanged. Bit 3 takes the written value.
- R7: `alarm_irq` is high exactly when both the flag and the interrupt enable are set.
- R8: A write that clears the flag in the same cycle as a ticked match leaves the flag set.
- R9: After reset the flag, the interrupt enable and `alarm_irq` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_sec | input | 1 | One-cycle pulse when the calendar seconds advance |
| cal_time | input | 48 | Live BCD calendar, one byte per field |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` |
| alarm_irq | output | 1 | Alarm interrupt |

## Verification
The hardest situation to reach from the ports is a flag-clearing write that lands in the very cycle of a ticked match. To reach it, the bench raises the write strobe and `tick_sec` at the same falling edge while the calendar already matches. A second case pairs the same clearing write with a mismatching calendar. The per-field masking is swept over all 64 enable subsets. For each subset the bench presents one calendar that matches exactly and six calendars that each spoil a single field, and derives the expected flag from the subset arithmetically.

// File: rtl/alarm_match.sv
module alarm_match #(
  parameter int NFIELDS = 6,
  parameter int FIELD_W = 8,
  parameter int ADDR_W  = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       tick_sec,
  input  logic [NFIELDS*FIELD_W-1:0] cal_time,
  input  logic                       reg_wr,
  input  logic [ADDR_W-1:0]          reg_addr,
  input  logic [FIELD_W-1:0]         reg_wdata,
  output logic [FIELD_W-1:0]         reg_rdata,
  output logic                       alarm_irq
);
  localparam int VAL_W     = FIELD_W - 1;
  localparam int CTRL_ADDR = NFIELDS;
  localparam int FLAG_BIT  = 0;
  localparam int IE_BIT    = 3;

  logic [FIELD_W-1:0] alarm_q [NFIELDS];
  logic [NFIELDS-1:0] fld_en;
  logic [NFIELDS-1:0] fld_ok;
  logic               flag_q;
  logic               ie_q;
  logic               ctrl_wr;
  logic               hit;

  for (genvar i = 0; i < NFIELDS; i++) begin : g_field
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        alarm_q[i] <= '0;
      else if (reg_wr && reg_addr == ADDR_W'(i))
        alarm_q[i] <= reg_wdata;
    end
    assign fld_en[i] = alarm_q[i][FIELD_W-1];
    assign fld_ok[i] = !fld_en[i] ||
                       (alarm_q[i][VAL_W-1:0] == cal_time[i*FIELD_W +: VAL_W]);
  end

  assign ctrl_wr = reg_wr && reg_addr == ADDR_W'(CTRL_ADDR);
  assign hit     = tick_sec && (|fld_en) && (&fld_ok);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      ie_q   <= 1'b0;
    end else if (ctrl_wr) begin
      flag_q <= (flag_q && reg_wdata[FLAG_BIT]) || hit;
      ie_q   <= reg_wdata[IE_BIT];
    end else begin
      flag_q <= flag_q || hit;
    end
  end

  always_comb begin
    reg_rdata = '0;
    for (int i = 0; i < NFIELDS; i++)
      if (reg_addr == ADDR_W'(i)) reg_rdata = alarm_q[i];
    if (reg_addr == ADDR_W'(CTRL_ADDR)) begin
      reg_rdata[FLAG_BIT] = flag_q;
      reg_rdata[IE_BIT]   = ie_q;
    end
  end

  assign alarm_irq = flag_q && ie_q;
endmodule

// File: rtl/alarm_match_chk.sv
module alarm_match_chk #(
  parameter int NFIELDS = 6,
  parameter int FIELD_W = 8,
  parameter int ADDR_W  = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               tick_sec,
  input logic               reg_wr,
  input logic [ADDR_W-1:0]  reg_addr,
  input logic [FIELD_W-1:0] reg_wdata,
  input logic [NFIELDS-1:0] fld_en,
  input logic               flag_q,
  input logic               alarm_irq
);
  logic ctl_w;
  assign ctl_w = reg_wr && reg_addr == ADDR_W'(NFIELDS);

  // R5
  flag_needs_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(tick_sec));

  // R4
  no_enable_no_alarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_sec && fld_en == '0 && !flag_q) |=> !flag_q);

  // R6
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_w && !reg_wdata[0] && !tick_sec) |=> !flag_q);

  // R6
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag_q) |-> $past(ctl_w && !reg_wdata[0]));

  // R7
  irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_w && !reg_wdata[3]) |=> !alarm_irq);
endmodule

bind alarm_match alarm_match_chk #(
  .NFIELDS(NFIELDS), .FIELD_W(FIELD_W), .ADDR_W(ADDR_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .tick_sec(tick_sec), .reg_wr(reg_wr),
  .reg_addr(reg_addr), .reg_wdata(reg_wdata), .fld_en(fld_en),
  .flag_q(flag_q), .alarm_irq(alarm_irq)
);

// File: tb/alarm_match_tb.sv
module alarm_match_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [2:0] CTRL = 3'd6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_sec = 1'b0;
  logic [47:0] cal_time = '0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = CTRL;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic        alarm_irq;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  logic [6:0] avals [6] = '{7'h37, 7'h45, 7'h13, 7'h04, 7'h28, 7'h11};

  alarm_match dut_i (
    .clk(clk), .rst_n(rst_n), .tick_sec(tick_sec), .cal_time(cal_time),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .alarm_irq(alarm_irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_addr = CTRL;
  endtask

  task automatic tick();
    @(negedge clk);
    tick_sec = 1'b1;
    @(negedge clk);
    tick_sec = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
    reg_addr = CTRL;
  endtask

  function automatic logic [47:0] full_match();
    logic [47:0] v = '0;
    for (int i = 0; i < 6; i++) v[i*8 +: 8] = {1'b0, avals[i]};
    return v;
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R9 reset state, R1 reset values
    rd(CTRL, d); chk("R9 ctrl after reset", d, 8'h00);
    chk("R9 irq after reset", {7'b0, alarm_irq}, 8'h00);
    for (int i = 0; i < 6; i++) begin
      rd(3'(i), d); chk("R1 field reset", d, 8'h00);
    end

    // R1 readback
    for (int i = 0; i < 6; i++) wr(3'(i), 8'h80 | 8'(i * 17));
    for (int i = 0; i < 6; i++) begin
      rd(3'(i), d); chk("R1 field readback", d, 8'h80 | 8'(i * 17));
    end

    // R4 nothing enabled, calendar equal to values
    for (int i = 0; i < 6; i++) wr(3'(i), {1'b0, avals[i]});
    cal_time = full_match();
    tick();
    rd(CTRL, d); chk("R4 no field enabled", d, 8'h00);

    // R5 matching calendar without tick
    for (int i = 0; i < 6; i++) wr(3'(i), {1'b1, avals[i]});
    wr(CTRL, 8'h08);
    repeat (5) @(negedge clk);
    rd(CTRL, d); chk("R5 no tick no flag", d, 8'h08);
    tick();
    rd(CTRL, d); chk("R5 tick sets flag", d, 8'h09);
    chk("R7 irq with flag and enable", {7'b0, alarm_irq}, 8'h01);

    // R6 write 1 to flag keeps it, other bits read 0
    wr(CTRL, 8'hFF);
    rd(CTRL, d); chk("R6 write one keeps flag", d, 8'h09);
    // R7 enable off masks irq
    wr(CTRL, 8'h01);
    rd(CTRL, d); chk("R6 ie cleared flag kept", d, 8'h01);
    chk("R7 irq masked", {7'b0, alarm_irq}, 8'h00);
    // R6 clear, R5 calendar still matching but no tick
    wr(CTRL, 8'h08);
    repeat (3) @(negedge clk);
    rd(CTRL, d); chk("R5 cleared stays cleared without tick", d, 8'h08);

    // R8 clear and match in same cycle
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = CTRL; reg_wdata = 8'h08; tick_sec = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; tick_sec = 1'b0;
    rd(CTRL, d); chk("R8 match wins over clear", d, 8'h09);
    cal_time[7:0] = 8'h00;
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = CTRL; reg_wdata = 8'h08; tick_sec = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; tick_sec = 1'b0;
    rd(CTRL, d); chk("R6 clear with mismatching tick", d, 8'h08);

    // R2 R3 R4 sweep over all enable subsets
    for (int m = 0; m < 64; m++) begin
      for (int i = 0; i < 6; i++) wr(3'(i), {m[i], avals[i]});
      for (int k = 0; k < 7; k++) begin
        logic [47:0] c;
        logic e;
        c = full_match();
        if (k < 6) c[k*8 +: 8] = c[k*8 +: 8] ^ 8'h01;
        else if (m[0]) c[7] = 1'b1;
        e = (m != 0) && (k == 6 || !m[k]);
        wr(CTRL, 8'h08);
        cal_time = c;
        tick();
        rd(CTRL, d);
        chk("R2 R3 sweep flag", d, 8'h08 | {7'b0, e});
        chk("R7 sweep irq", {7'b0, alarm_irq}, {7'b0, e});
      end
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule